// File: doc/BRIEF.md
# Card Host Data Buffer with Threshold DMA Requests

This block is the data staging buffer of a memory-card host controller. It stores up to 32 words of 16 bits between the processor-facing register port and the card-facing core logic. The direction of the current transfer decides who fills and who drains the buffer. When the card is being read, the core pushes words and software or DMA pops them through the data register. When the card is being written, the register port pushes and the core pops.

Two programmable 5-bit levels watch the fill count. In the read direction, a count above the upper level either raises a receive DMA request or sets a status flag. In the write direction, a count below the lower level either raises a transmit DMA request or sets a different status flag. A per-direction DMA enable decides which of the two happens. The status flags feed a single level interrupt through an enable mask. The register port decodes four locations: data at address 0, buffer configuration at 1, status at 2 (read only) and interrupt mask at 3.

Top module: `card_fifo_thresh`

## Requirements
- R1: Words leave the buffer in the order they entered, across any number of wraps of the 32-entry storage, and the fill count tracks every accepted push and pop.
- R2: The configuration register (address 1) holds the receive DMA enable in bit 15, the upper level in bits 12:8, the transmit DMA enable in bit 7 and the lower level in bits 4:0, and reads back in those positions. Its reset value is upper level 0x1F, lower level 0x00 and both enables clear, which reads as 0x1F00.
- R3: A push while 32 words are held is dropped: neither the count nor the stored contents change.
- R4: When dir_rd_i is high and the count is above the upper level, rx_dreq_o is high and af_flag_o is low if receive DMA is enabled. If receive DMA is disabled, af_flag_o is high and rx_dreq_o is low. At or below the level, both are low.
- R5: When dir_rd_i is low and the count is below the lower level, tx_dreq_o is high and ae_flag_o is low if transmit DMA is enabled. If transmit DMA is disabled, ae_flag_o is high and tx_dreq_o is low. At or above the level, both are low.
- R6: With xfer_i low and the buffer empty, both flags and both requests are low.
- R7: The status register (address 2) shows af_flag_o in bit 11 and ae_flag_o in bit 10. irq_o is high exactly when some status bit is set whose bit in the mask register (address 3) is also set.
- R8: A data-register read of an empty buffer returns the word at the current read slot and moves no pointer. It sets underrun_o, which stays high until reset.
- R9: Flags and requests reflect the count, levels and enables in effect after each clock edge. This includes a configuration write, which takes effect at the same edge that stores it.
- R10: With dir_rd_i high, only core pushes and data-register reads move data. With dir_rd_i low, only data-register writes and core pops move data. The other side's push or pop has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a data read pops) |
| reg_adr_i | input | 2 | Register address: 0 data, 1 config, 2 status, 3 mask |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| core_push_i | input | 1 | Core push of a received word |
| core_wdata_i | input | 16 | Core push data |
| core_pop_i | input | 1 | Core pop of a word to transmit |
| core_rdata_o | output | 16 | Word at the read slot |
| xfer_i | input | 1 | A data transfer is in progress |
| dir_rd_i | input | 1 | 1 = card-to-host, 0 = host-to-card |
| fill_o | output | 6 | Number of words held |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |
| af_flag_o | output | 1 | Almost-full status flag |
| ae_flag_o | output | 1 | Almost-empty status flag |
| irq_o | output | 1 | Masked status interrupt |
| underrun_o | output | 1 | Sticky empty-read indication |

## Verification
A corrupted read or write index shows on the next pop as a word out of order. The scoreboard catches it at once. A lost or doubled count shows on fill_o one cycle after the faulty push or pop, and soon after on a request line that changes at the wrong occupancy. Because flags are registered at the same edge as the count and the configuration, any mismatch in threshold comparison or enable steering is visible on rx_dreq_o, tx_dreq_o or the flags one cycle after the stimulus. The stale-slot value returned on an empty read exposes a pointer that moved when it should not have.

// File: rtl/cfq_pkg.sv
package cfq_pkg;
  localparam int unsigned LVL_W  = 5;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned AE_BIT = 10;
  localparam int unsigned AF_BIT = 11;

  typedef enum logic [1:0] {
    ADR_DATA  = 2'd0,
    ADR_BUF   = 2'd1,
    ADR_STAT  = 2'd2,
    ADR_IMASK = 2'd3
  } reg_adr_e;

  typedef struct packed {
    logic             rx_dma_en;
    logic [LVL_W-1:0] full_lvl;
    logic             tx_dma_en;
    logic [LVL_W-1:0] empty_lvl;
  } buf_cfg_t;

  localparam buf_cfg_t CFG_RST = '{rx_dma_en: 1'b0, full_lvl: '1,
                                   tx_dma_en: 1'b0, empty_lvl: '0};

  function automatic logic [REG_W-1:0] cfg_pack(buf_cfg_t c);
    logic [REG_W-1:0] v;
    v = '0;
    v[15]   = c.rx_dma_en;
    v[12:8] = c.full_lvl;
    v[7]    = c.tx_dma_en;
    v[4:0]  = c.empty_lvl;
    return v;
  endfunction

  function automatic buf_cfg_t cfg_unpack(logic [REG_W-1:0] v);
    buf_cfg_t c;
    c.rx_dma_en = v[15];
    c.full_lvl  = v[12:8];
    c.tx_dma_en = v[7];
    c.empty_lvl = v[4:0];
    return c;
  endfunction
endpackage

// File: rtl/cfq_store.sv
module cfq_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] fill_o,
  output logic [CNT_W-1:0] fill_n_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [IDX_W-1:0] wr_idx_q, rd_idx_q;
  logic [CNT_W-1:0] fill_q;
  logic             push_ok, pop_ok;

  assign push_ok = push_i && (fill_q != FULL_CNT);
  assign pop_ok  = pop_i && (fill_q != '0);

  always_comb begin
    fill_n_o = fill_q;
    if (push_ok && !pop_ok) fill_n_o = fill_q + 1'b1;
    if (pop_ok && !push_ok) fill_n_o = fill_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      fill_q   <= '0;
    end else begin
      fill_q <= fill_n_o;
      if (push_ok) wr_idx_q <= wr_idx_q + 1'b1;  // wraps modulo DEPTH
      if (pop_ok)  rd_idx_q <= rd_idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_idx_q] <= wdata_i;
  end

  assign head_o = mem_q[rd_idx_q];
  assign fill_o = fill_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FULL_CNT);

  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && fill_q == FULL_CNT) |=> (fill_q == FULL_CNT && $stable(wr_idx_q)));

  assert_empty_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && fill_q == '0) |=> $stable(rd_idx_q));
endmodule

// File: rtl/cfq_regs.sv
module cfq_regs
  import cfq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [1:0]    adr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] head_i,
  input  logic [DW-1:0] stat_i,
  output buf_cfg_t      cfg_o,
  output buf_cfg_t      cfg_n_o,
  output logic [DW-1:0] mask_o,
  output logic          data_wr_o,
  output logic          data_rd_o,
  output logic [DW-1:0] rdata_o
);
  reg_adr_e  adr;
  buf_cfg_t  cfg_q;
  logic [DW-1:0] mask_q;

  assign adr       = reg_adr_e'(adr_i);
  assign data_wr_o = wr_i && (adr == ADR_DATA);
  assign data_rd_o = rd_i && (adr == ADR_DATA);

  always_comb begin
    cfg_n_o = cfg_q;
    if (wr_i && adr == ADR_BUF) cfg_n_o = cfg_unpack(REG_W'(wdata_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      mask_q <= '0;
    end else begin
      cfg_q <= cfg_n_o;
      if (wr_i && adr == ADR_IMASK) mask_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (adr)
      ADR_DATA:  rdata_o = head_i;
      ADR_BUF:   rdata_o = DW'(cfg_pack(cfg_q));
      ADR_STAT:  rdata_o = stat_i;
      ADR_IMASK: rdata_o = mask_q;
      default:   rdata_o = '0;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/cfq_thresh.sv
module cfq_thresh
  import cfq_pkg::*;
#(
  parameter int unsigned CNT_W = LVL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fill_n_i,
  input  buf_cfg_t         cfg_n_i,
  input  logic             xfer_i,
  input  logic             dir_rd_i,
  output logic             rx_dreq_o,
  output logic             tx_dreq_o,
  output logic             af_o,
  output logic             ae_o
);
  logic rx_n, tx_n, af_n, ae_n;
  logic over_hi, under_lo;

  // levels zero-extended to the count width
  assign over_hi  = fill_n_i > CNT_W'(cfg_n_i.full_lvl);
  assign under_lo = fill_n_i < CNT_W'(cfg_n_i.empty_lvl);

  always_comb begin
    rx_n = 1'b0;
    tx_n = 1'b0;
    af_n = 1'b0;
    ae_n = 1'b0;
    if (xfer_i || fill_n_i != '0) begin
      if (dir_rd_i && over_hi) begin
        if (cfg_n_i.rx_dma_en) rx_n = 1'b1;
        else                   af_n = 1'b1;
      end
      if (!dir_rd_i && under_lo) begin
        if (cfg_n_i.tx_dma_en) tx_n = 1'b1;
        else                   ae_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_dreq_o <= 1'b0;
      tx_dreq_o <= 1'b0;
      af_o      <= 1'b0;
      ae_o      <= 1'b0;
    end else begin
      rx_dreq_o <= rx_n;
      tx_dreq_o <= tx_n;
      af_o      <= af_n;
      ae_o      <= ae_n;
    end
  end
endmodule

// File: rtl/card_fifo_thresh.sv
module card_fifo_thresh
  import cfq_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [1:0]       reg_adr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             core_push_i,
  input  logic [DW-1:0]    core_wdata_i,
  input  logic             core_pop_i,
  output logic [DW-1:0]    core_rdata_o,
  input  logic             xfer_i,
  input  logic             dir_rd_i,
  output logic [CNT_W-1:0] fill_o,
  output logic             rx_dreq_o,
  output logic             tx_dreq_o,
  output logic             af_flag_o,
  output logic             ae_flag_o,
  output logic             irq_o,
  output logic             underrun_o
);
  logic [DW-1:0]    head, stat_word, mask, push_data;
  logic [CNT_W-1:0] fill, fill_n;
  logic             data_wr, data_rd, push, pop, underrun_q;
  buf_cfg_t         cfg, cfg_n;

  cfq_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .adr_i(reg_adr_i), .wdata_i(reg_wdata_i),
    .head_i(head), .stat_i(stat_word),
    .cfg_o(cfg), .cfg_n_o(cfg_n), .mask_o(mask),
    .data_wr_o(data_wr), .data_rd_o(data_rd), .rdata_o(reg_rdata_o)
  );

  // producer and consumer follow the transfer direction
  assign push      = dir_rd_i ? core_push_i  : data_wr;
  assign push_data = dir_rd_i ? core_wdata_i : reg_wdata_i;
  assign pop       = dir_rd_i ? data_rd      : core_pop_i;

  cfq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(push), .wdata_i(push_data), .pop_i(pop),
    .head_o(head), .fill_o(fill), .fill_n_o(fill_n)
  );

  cfq_thresh #(.CNT_W(CNT_W)) u_thresh (
    .clk_i, .rst_ni,
    .fill_n_i(fill_n), .cfg_n_i(cfg_n), .xfer_i, .dir_rd_i,
    .rx_dreq_o, .tx_dreq_o, .af_o(af_flag_o), .ae_o(ae_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      underrun_q <= 1'b0;
    else if (data_rd && fill == '0)   underrun_q <= 1'b1;
  end

  always_comb begin
    stat_word         = '0;
    stat_word[AF_BIT] = af_flag_o;
    stat_word[AE_BIT] = ae_flag_o;
  end

  assign irq_o        = |(stat_word & mask);
  assign core_rdata_o = head;
  assign fill_o       = fill;
  assign underrun_o   = underrun_q;

  assert_rx_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dreq_o |-> (fill > CNT_W'(cfg.full_lvl) && cfg.rx_dma_en && !af_flag_o));

  assert_tx_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dreq_o |-> (fill < CNT_W'(cfg.empty_lvl) && cfg.tx_dma_en && !ae_flag_o));

  assert_idle_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(xfer_i) && fill == '0) |-> !(af_flag_o || ae_flag_o || rx_dreq_o || tx_dreq_o));

  assert_underrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_q |=> underrun_q);
endmodule

// File: tb/card_fifo_thresh_tb_top.sv
module card_fifo_thresh_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_adr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        core_push = 1'b0, core_pop = 1'b0;
  logic [15:0] core_wdata = '0, core_rdata;
  logic        xfer = 1'b0, dir_rd = 1'b0;
  logic [5:0]  fill;
  logic        rx_dreq, tx_dreq, af_flag, ae_flag, irq, underrun;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  card_fifo_thresh dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_adr_i(reg_adr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .core_push_i(core_push), .core_wdata_i(core_wdata),
    .core_pop_i(core_pop), .core_rdata_o(core_rdata),
    .xfer_i(xfer), .dir_rd_i(dir_rd), .fill_o(fill),
    .rx_dreq_o(rx_dreq), .tx_dreq_o(tx_dreq),
    .af_flag_o(af_flag), .ae_flag_o(ae_flag),
    .irq_o(irq), .underrun_o(underrun)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] v);
    reg_wr = 1'b1; reg_adr = a; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic reg_peek(input logic [1:0] a, output logic [15:0] v);
    reg_rd = 1'b1; reg_adr = a;
    #2 v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic push_reg(input logic [15:0] v, input bit accept);
    if (accept) exp_q.push_back(v);
    reg_write(2'd0, v);
  endtask

  task automatic push_core(input logic [15:0] v, input bit accept);
    if (accept) exp_q.push_back(v);
    core_push = 1'b1; core_wdata = v;
    tick();
    core_push = 1'b0;
  endtask

  task automatic pop_core();
    core_pop = 1'b1;
    tick();
    core_pop = 1'b0;
  endtask

  task automatic pop_reg();
    reg_rd = 1'b1; reg_adr = 2'd0;
    tick();
    reg_rd = 1'b0;
  endtask

  // scoreboard monitor: compares each consumed word between drive and edge
  always @(negedge clk) begin
    if (rst_n && fill != 0 &&
        ((core_pop && !dir_rd) || (reg_rd && reg_adr == 2'd0 && dir_rd))) begin
      logic [15:0] got;
      got = dir_rd ? reg_rdata : core_rdata;
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected pop", got, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(got == e, "R1 order", got, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    reg_peek(2'd1, v);
    check(v == 16'h1F00, "R2 reset config", v, 16'h1F00);
    check({fill, rx_dreq, tx_dreq, af_flag, ae_flag, irq, underrun} == '0, "R2 reset outputs",
          {fill, rx_dreq, tx_dreq, af_flag, ae_flag, irq, underrun}, 0);

    // write direction, tx DMA on, lower level 6, upper level 4, rx DMA on
    xfer = 1'b1; dir_rd = 1'b0;
    tick();
    reg_write(2'd1, 16'h8486);
    check(tx_dreq && !ae_flag, "R9 config edge tx", {tx_dreq, ae_flag}, 2'b10);
    reg_peek(2'd1, v);
    check(v == 16'h8486, "R2 readback", v, 16'h8486);

    for (int i = 0; i < 5; i++) push_reg(16'h1000 + 16'(i), 1'b1);
    check(fill == 5 && tx_dreq, "R5 below level", {fill, tx_dreq}, {6'd5, 1'b1});
    push_reg(16'h1005, 1'b1);
    check(fill == 6 && !tx_dreq && !ae_flag, "R5 at level", {fill, tx_dreq, ae_flag}, {6'd6, 2'b00});

    reg_write(2'd1, 16'h0406);  // DMA off both sides
    check(!ae_flag && !tx_dreq, "R5 at level no dma", {tx_dreq, ae_flag}, 2'b00);
    pop_core();
    check(ae_flag && !tx_dreq && fill == 5, "R5 flag when dma off", {fill, tx_dreq, ae_flag}, {6'd5, 2'b01});

    reg_write(2'd3, 16'h0400);
    check(irq, "R7 ae masked in", irq, 1);
    reg_peek(2'd2, v);
    check(v == 16'h0400, "R7 status bit 10", v, 16'h0400);
    reg_write(2'd3, 16'h0800);
    check(!irq, "R7 other bit masked", irq, 0);

    push_core(16'hDEAD, 1'b0);
    check(fill == 5, "R10 core push in write dir", fill, 5);

    for (int i = 0; i < 5; i++) pop_core();
    check(ae_flag && fill == 0, "R5 empty active", {fill, ae_flag}, {6'd0, 1'b1});
    xfer = 1'b0;
    tick();
    check(!ae_flag && !tx_dreq && !af_flag && !rx_dreq, "R6 idle empty",
          {rx_dreq, tx_dreq, af_flag, ae_flag}, 0);

    // fill to 32 across the wrap, then overflow attempt
    xfer = 1'b1;
    for (int i = 0; i < 32; i++) push_reg(16'h3000 + 16'(i), 1'b1);
    check(fill == 32, "R3 full count", fill, 32);
    push_reg(16'hBEEF, 1'b0);
    check(fill == 32, "R3 full drop", fill, 32);
    for (int i = 0; i < 32; i++) pop_core();
    check(fill == 0 && exp_q.size() == 0, "R1 drained after wrap", {fill, 8'(exp_q.size())}, 0);

    // read direction
    dir_rd = 1'b1;
    reg_write(2'd1, 16'h8400);
    for (int i = 0; i < 4; i++) push_core(16'h5000 + 16'(i), 1'b1);
    check(fill == 4 && !rx_dreq && !af_flag, "R4 at level", {fill, rx_dreq, af_flag}, {6'd4, 2'b00});
    push_core(16'h5004, 1'b1);
    check(rx_dreq && !af_flag, "R4 above level dma", {rx_dreq, af_flag}, 2'b10);
    reg_write(2'd1, 16'h0400);
    check(!rx_dreq && af_flag, "R9 config edge rx", {rx_dreq, af_flag}, 2'b01);
    reg_peek(2'd2, v);
    check(v == 16'h0800, "R7 status bit 11", v, 16'h0800);

    push_reg(16'hAAAA, 1'b0);
    check(fill == 5, "R10 reg write in read dir", fill, 5);
    pop_core();
    check(fill == 5, "R10 core pop in read dir", fill, 5);

    pop_reg();
    check(fill == 4 && !af_flag, "R4 back to level", {fill, af_flag}, {6'd4, 1'b0});
    for (int i = 0; i < 4; i++) pop_reg();

    // empty read: read slot 11 still holds 0x3005
    reg_peek(2'd0, v);
    check(v == 16'h3005, "R8 stale slot", v, 16'h3005);
    pop_reg();
    check(underrun && fill == 0, "R8 underrun set", {underrun, fill}, {1'b1, 6'd0});
    push_core(16'h6000, 1'b1);
    pop_reg();
    check(underrun && exp_q.size() == 0, "R8 sticky, pointers kept", {underrun, 8'(exp_q.size())}, {1'b1, 8'd0});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule